// File: doc/BRIEF.md
# Bus Dominant-Duration Watch Timers

This block observes the received level of a single-wire LIN/CXPI transceiver and measures how long the bus stays dominant (logic 0), using a low-frequency clock. One counter recognises a wakeup request: a dominant pulse that lasts at least a programmed number of clock cycles. A second counter flags a bus that has been stuck dominant for too long. Each counter has its own enable, a programmable threshold and a count that can be read back while it runs.

Three interrupt sources share one status/set/mask set: wakeup, dominant fault and a rising thermal-shutdown flag. Status bits are cleared by writing ones. Software can force them through a set register. A masked view and a single interrupt line follow from status and mask. A write port configures the block and a read port with one cycle of latency returns registers. When the transceiver acts as a CXPI slave node, the wakeup counter ignores its programmed threshold and fires on the first dominant cycle.

Register addresses: 0 control (bit0 wakeup enable, bit1 fault enable, bit2 CXPI-slave), 1 wakeup threshold, 2 fault threshold, 3 wakeup count (read only), 4 fault count (read only), 5 status, 6 set, 7 mask, 8 masked status (read only). Interrupt bits: bit0 wakeup, bit1 fault, bit2 thermal.

Top module: `busdom_watch`

## Requirements
- R1: After reset every register reads zero (addresses 0 to 8) and `irq` is low.
- R2: `bus_rx` passes through two synchronizer flops: when the wakeup condition is met on the first dominant cycle, `irq` (with the wakeup mask set) is still low two clock edges after `bus_rx` falls and high after the third.
- R3: With bit0 of address 0 set, the wakeup count at address 3 rises by one per dominant cycle, stops at the threshold at address 1, and status bit0 is set when the count reaches that threshold; a pulse of exactly threshold cycles fires.
- R4: When the bus returns recessive, a count falls back to zero. A pulse one cycle shorter than the threshold raises nothing.
- R5: With bit1 of address 0 set, the fault count at address 4 behaves in the same way against the threshold at address 2 and sets status bit1.
- R6: With bit2 of address 0 set, the wakeup counter uses a fixed threshold of one cycle and ignores address 1. Without bit2, the same short pulse against a large threshold raises nothing.
- R7: A disabled counter stays at zero and raises no status, however long the bus stays dominant.
- R8: A threshold of zero never raises its event, and its count stays at zero.
- R9: A rising edge of `tsd_in` sets status bit2. A level held high does not set it again after it has been cleared.
- R10: Writing ones to address 5 clears those status bits and leaves the others unchanged.
- R11: Writing ones to address 6 sets those status bits. Address 6 reads zero.
- R12: Address 8 reads status AND mask (mask at address 7), and `irq` is high exactly when any masked bit is set.
- R13: An event or a set in the same cycle as a write-one-to-clear of the same bit leaves the bit set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Low-frequency clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_rx | input | 1 | Received bus level, asynchronous, 0 = dominant |
| tsd_in | input | 1 | Thermal-shutdown flag, asynchronous, high while over temperature |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Write address |
| wr_data | input | DATA_W | Write data |
| rd_en | input | 1 | Register read strobe |
| rd_addr | input | ADDR_W | Read address |
| rd_valid | output | 1 | Read data valid, one cycle after `rd_en` |
| rd_data | output | DATA_W | Read data |
| irq | output | 1 | OR of the masked status bits |

## Verification
On every cycle the assertions check that a count is zero after any cycle with the bus recessive or the counter disabled, that a threshold hit leaves the count equal to the threshold and that the count then holds, that an event or set beats a clear, that a clear without one empties the bit, that `irq` matches status and mask, and that the CXPI-slave mode fires on the first dominant cycle. Only the bench's scenarios can show the exact pulse-length boundaries, the synchronizer latency seen at the pins, the edge-only behaviour of the thermal flag, readback of running counts and the zero-threshold and disabled cases.

// File: rtl/busdom_pkg.sv
package busdom_pkg;
  localparam int IRQ_N     = 3;
  localparam int IRQ_WAKE  = 0;
  localparam int IRQ_FAULT = 1;
  localparam int IRQ_TSD   = 2;
  localparam int CTRL_W    = 3;
  localparam int CTRL_WEN  = 0;
  localparam int CTRL_FEN  = 1;
  localparam int CTRL_SLV  = 2;

  typedef enum logic [3:0] {
    A_CTRL = 4'd0,
    A_WLIM = 4'd1,
    A_FLIM = 4'd2,
    A_WCNT = 4'd3,
    A_FCNT = 4'd4,
    A_STAT = 4'd5,
    A_SET  = 4'd6,
    A_MASK = 4'd7,
    A_MSKD = 4'd8
  } reg_addr_e;
endpackage

// File: rtl/busdom_sync.sv
module busdom_sync #(
  parameter int W = 1,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  generate
    if (STAGES == 1) begin : g_single
      logic [W-1:0] s_q;
      always_ff @(posedge clk) begin
        if (rst) s_q <= RST_VAL;
        else     s_q <= d;
      end
      assign q = s_q;
    end else begin : g_chain
      logic [STAGES-1:0][W-1:0] chain_q;
      always_ff @(posedge clk) begin
        if (rst) chain_q <= {STAGES{RST_VAL}};
        else     chain_q <= {chain_q[STAGES-2:0], d};
      end
      assign q = chain_q[STAGES-1];
    end
  endgenerate
endmodule

// File: rtl/busdom_timer.sv
module busdom_timer #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             dom,
  input  logic [CNT_W-1:0] limit,
  output logic [CNT_W-1:0] count,
  output logic             hit
);
  always_ff @(posedge clk) begin
    if (rst)               count <= '0;
    else if (!en || !dom)  count <= '0;
    else if (count < limit) count <= count + 1'b1;
  end

  assign hit = en && dom && (limit != '0) && (count == limit - 1'b1);

  assert_restart_R4: assert property (@(posedge clk) disable iff (rst)
    $past(!en || !dom) |-> (count == '0));

  assert_hit_count_R3: assert property (@(posedge clk) disable iff (rst)
    hit |=> (count == $past(limit)));

  assert_hold_R3: assert property (@(posedge clk) disable iff (rst)
    (en && dom && (count >= limit)) |=> (count == $past(count)));
endmodule

// File: rtl/busdom_irq.sv
module busdom_irq #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] ev,
  input  logic [N-1:0] set_w,
  input  logic [N-1:0] clr_w,
  input  logic         mask_we,
  input  logic [N-1:0] mask_wd,
  output logic [N-1:0] status,
  output logic [N-1:0] mask,
  output logic         irq
);
  logic [N-1:0] status_d;
  logic [N-1:0] mask_d;

  always_comb begin
    status_d = (status & ~clr_w) | set_w | ev;
    mask_d   = mask_we ? mask_wd : mask;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      status <= '0;
      mask   <= '0;
      irq    <= 1'b0;
    end else begin
      status <= status_d;
      mask   <= mask_d;
      irq    <= |(status_d & mask_d);
    end
  end

  assert_irq_view_R12: assert property (@(posedge clk) disable iff (rst)
    irq == |(status & mask));

  for (genvar g = 0; g < N; g++) begin : g_bit_chk
    assert_set_wins_R13: assert property (@(posedge clk) disable iff (rst)
      (ev[g] || set_w[g]) |=> status[g]);
    assert_w1c_R10: assert property (@(posedge clk) disable iff (rst)
      (clr_w[g] && !ev[g] && !set_w[g]) |=> !status[g]);
  end
endmodule

// File: rtl/busdom_watch.sv
module busdom_watch
  import busdom_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int DATA_W = 16,
  parameter int ADDR_W = 4,
  parameter int SYNC_STAGES = 2,
  parameter int CXPI_WAKE_LIMIT = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_rx,
  input  logic              tsd_in,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  output logic              irq
);
  localparam logic [CNT_W-1:0] SLV_LIM = CNT_W'(CXPI_WAKE_LIMIT);

  logic [CTRL_W-1:0] ctrl_q;
  logic [CNT_W-1:0]  wlim_q, flim_q, wlim_eff;
  logic [CNT_W-1:0]  wcnt, fcnt;
  logic [1:0]        raw_in, sync_out;
  logic              dom, tsd_s, tsd_prev_q, tsd_rise;
  logic              wake_hit, fault_hit;
  logic [IRQ_N-1:0]  events, set_w, clr_w, status, mask;
  logic              mask_we;
  logic [DATA_W-1:0] rd_mux;

  assign raw_in = {tsd_in, bus_rx};

  busdom_sync #(.W(2), .STAGES(SYNC_STAGES), .RST_VAL(2'b01)) u_sync (
    .clk(clk), .rst(rst), .d(raw_in), .q(sync_out)
  );

  assign dom   = !sync_out[0];
  assign tsd_s = sync_out[1];

  always_ff @(posedge clk) begin
    if (rst) tsd_prev_q <= 1'b0;
    else     tsd_prev_q <= tsd_s;
  end
  assign tsd_rise = tsd_s && !tsd_prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0;
      wlim_q <= '0;
      flim_q <= '0;
    end else if (wr_en) begin
      if (wr_addr == ADDR_W'(A_CTRL)) ctrl_q <= wr_data[CTRL_W-1:0];
      if (wr_addr == ADDR_W'(A_WLIM)) wlim_q <= wr_data[CNT_W-1:0];
      if (wr_addr == ADDR_W'(A_FLIM)) flim_q <= wr_data[CNT_W-1:0];
    end
  end

  assign wlim_eff = ctrl_q[CTRL_SLV] ? SLV_LIM : wlim_q;

  busdom_timer #(.CNT_W(CNT_W)) u_wake (
    .clk(clk), .rst(rst), .en(ctrl_q[CTRL_WEN]), .dom(dom),
    .limit(wlim_eff), .count(wcnt), .hit(wake_hit)
  );

  busdom_timer #(.CNT_W(CNT_W)) u_fault (
    .clk(clk), .rst(rst), .en(ctrl_q[CTRL_FEN]), .dom(dom),
    .limit(flim_q), .count(fcnt), .hit(fault_hit)
  );

  always_comb begin
    events = '0;
    events[IRQ_WAKE]  = wake_hit;
    events[IRQ_FAULT] = fault_hit;
    events[IRQ_TSD]   = tsd_rise;
    set_w   = (wr_en && wr_addr == ADDR_W'(A_SET))  ? wr_data[IRQ_N-1:0] : '0;
    clr_w   = (wr_en && wr_addr == ADDR_W'(A_STAT)) ? wr_data[IRQ_N-1:0] : '0;
    mask_we = wr_en && (wr_addr == ADDR_W'(A_MASK));
  end

  busdom_irq #(.N(IRQ_N)) u_irq (
    .clk(clk), .rst(rst), .ev(events), .set_w(set_w), .clr_w(clr_w),
    .mask_we(mask_we), .mask_wd(wr_data[IRQ_N-1:0]),
    .status(status), .mask(mask), .irq(irq)
  );

  always_comb begin
    rd_mux = '0;
    case (rd_addr)
      ADDR_W'(A_CTRL): rd_mux = DATA_W'(ctrl_q);
      ADDR_W'(A_WLIM): rd_mux = DATA_W'(wlim_q);
      ADDR_W'(A_FLIM): rd_mux = DATA_W'(flim_q);
      ADDR_W'(A_WCNT): rd_mux = DATA_W'(wcnt);
      ADDR_W'(A_FCNT): rd_mux = DATA_W'(fcnt);
      ADDR_W'(A_STAT): rd_mux = DATA_W'(status);
      ADDR_W'(A_MASK): rd_mux = DATA_W'(mask);
      ADDR_W'(A_MSKD): rd_mux = DATA_W'(status & mask);
      default:         rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= rd_en;
      if (rd_en) rd_data <= rd_mux;
    end
  end

  assert_slave_fast_R6: assert property (@(posedge clk) disable iff (rst)
    (ctrl_q[CTRL_WEN] && ctrl_q[CTRL_SLV] && dom && wcnt == '0) |-> wake_hit);
endmodule

// File: tb/busdom_watch_tb.sv
module busdom_watch_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_rx = 1'b1;
  logic        tsd_in = 1'b0;
  logic        wr_en = 1'b0;
  logic [3:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic        rd_en = 1'b0;
  logic [3:0]  rd_addr = '0;
  logic        rd_valid;
  logic [15:0] rd_data;
  logic        irq;

  int checks = 0;
  int fails = 0;
  logic [15:0] exp_q[$];
  string       tag_q[$];

  always #5 clk = ~clk;

  busdom_watch dut_i (
    .clk(clk), .rst(rst), .bus_rx(bus_rx), .tsd_in(tsd_in),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_valid(rd_valid),
    .rd_data(rd_data), .irq(irq)
  );

  // monitor: pops expected read results as the design returns them
  always @(negedge clk) begin
    if (rd_valid) begin
      checks++;
      if (exp_q.size() == 0) begin
        fails++;
        $display("FAIL unexpected read: actual %0h expected none", rd_data);
      end else begin
        automatic logic [15:0] e = exp_q.pop_front();
        automatic string t = tag_q.pop_front();
        if (rd_data !== e) begin
          fails++;
          $display("FAIL %s: actual %0h expected %0h", t, rd_data, e);
        end
      end
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic expect_rd(input logic [3:0] a, input logic [15:0] e, input string t);
    @(negedge clk);
    rd_en = 1'b1; rd_addr = a;
    exp_q.push_back(e); tag_q.push_back(t);
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic chk_irq(input logic e, input string t);
    checks++;
    if (irq !== e) begin
      fails++;
      $display("FAIL %s: irq actual %0b expected %0b", t, irq, e);
    end
  endtask

  task automatic dominant(input int n);
    @(negedge clk);
    bus_rx = 1'b0;
    repeat (n) @(negedge clk);
    bus_rx = 1'b1;
    idle(4);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run did not finish");
    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

  initial begin
    idle(4);
    rst = 1'b0;
    idle(1);
    // R1 reset state
    chk_irq(1'b0, "R1 irq after reset");
    for (int a = 0; a <= 8; a++) expect_rd(4'(a), 16'h0, "R1 reset value");

    // R4 short pulse, R3 exact pulse and running readback
    wr(4'd0, 16'h1); wr(4'd1, 16'd5);
    dominant(4);
    expect_rd(4'd5, 16'h0, "R4 pulse one short of threshold");
    expect_rd(4'd3, 16'h0, "R4 wake count restarts");
    dominant(5);
    expect_rd(4'd5, 16'h1, "R3 wake at threshold");
    expect_rd(4'd3, 16'h0, "R4 wake count zero after release");
    @(negedge clk); bus_rx = 1'b0;
    idle(10);
    expect_rd(4'd3, 16'd5, "R3 wake count holds at threshold");
    bus_rx = 1'b1; idle(4);
    wr(4'd5, 16'h7);

    // R5 fault timer
    wr(4'd0, 16'h2); wr(4'd2, 16'd8);
    dominant(7);
    expect_rd(4'd5, 16'h0, "R5 fault one short");
    dominant(8);
    expect_rd(4'd5, 16'h2, "R5 fault at threshold");
    @(negedge clk); bus_rx = 1'b0;
    idle(14);
    expect_rd(4'd4, 16'd8, "R5 fault count readback");
    bus_rx = 1'b1; idle(4);
    expect_rd(4'd4, 16'd0, "R4 fault count restarts");
    wr(4'd5, 16'h7);

    // R7 disabled timers
    wr(4'd0, 16'h0); wr(4'd1, 16'd2); wr(4'd2, 16'd2);
    @(negedge clk); bus_rx = 1'b0;
    idle(10);
    expect_rd(4'd3, 16'd0, "R7 disabled wake count");
    expect_rd(4'd4, 16'd0, "R7 disabled fault count");
    bus_rx = 1'b1; idle(4);
    expect_rd(4'd5, 16'h0, "R7 disabled no status");

    // R8 zero threshold
    wr(4'd0, 16'h3); wr(4'd1, 16'd0); wr(4'd2, 16'd0);
    @(negedge clk); bus_rx = 1'b0;
    idle(12);
    expect_rd(4'd3, 16'd0, "R8 zero threshold wake count");
    bus_rx = 1'b1; idle(4);
    expect_rd(4'd5, 16'h0, "R8 zero threshold no status");
    wr(4'd0, 16'h0);

    // R11 set, R10 clear
    wr(4'd6, 16'h7);
    expect_rd(4'd5, 16'h7, "R11 set forces status");
    expect_rd(4'd6, 16'h0, "R11 set reads zero");
    wr(4'd5, 16'h5);
    expect_rd(4'd5, 16'h2, "R10 w1c clears only ones");
    wr(4'd5, 16'h7);

    // R9 thermal edge
    @(negedge clk); tsd_in = 1'b1; idle(5);
    expect_rd(4'd5, 16'h4, "R9 thermal rise sets status");
    wr(4'd5, 16'h4); idle(3);
    expect_rd(4'd5, 16'h0, "R9 held level does not reassert");
    @(negedge clk); tsd_in = 1'b0; idle(5);
    @(negedge clk); tsd_in = 1'b1; idle(5);
    expect_rd(4'd5, 16'h4, "R9 second rise sets status");
    wr(4'd5, 16'h7);

    // R12 mask and masked view
    wr(4'd6, 16'h3); wr(4'd7, 16'h2); idle(1);
    expect_rd(4'd8, 16'h2, "R12 masked view");
    chk_irq(1'b1, "R12 irq with masked bit");
    wr(4'd7, 16'h4); idle(1);
    expect_rd(4'd8, 16'h0, "R12 masked view empty");
    chk_irq(1'b0, "R12 irq without masked bit");
    wr(4'd5, 16'h7); wr(4'd7, 16'h1);

    // R6 contrast: large threshold without slave mode
    wr(4'd0, 16'h1); wr(4'd1, 16'd50);
    dominant(4);
    expect_rd(4'd5, 16'h0, "R6 no wake without slave mode");
    // R2 and R6: slave mode fires on first synchronized dominant cycle
    wr(4'd0, 16'h5);
    @(negedge clk); bus_rx = 1'b0;
    @(negedge clk);
    @(negedge clk);
    chk_irq(1'b0, "R2 two edges after fall");
    @(negedge clk);
    chk_irq(1'b1, "R6 slave wake after third edge");
    bus_rx = 1'b1; idle(4);
    expect_rd(4'd5, 16'h1, "R6 slave wake status");
    wr(4'd5, 16'h7); wr(4'd7, 16'h0); idle(1);
    chk_irq(1'b0, "R10 irq low after clear");

    // R13 event coincides with clear
    wr(4'd0, 16'h2); wr(4'd2, 16'd3); wr(4'd6, 16'h2);
    @(negedge clk); bus_rx = 1'b0;
    idle(4);
    wr_en = 1'b1; wr_addr = 4'd5; wr_data = 16'h2;
    @(negedge clk);
    wr_en = 1'b0; bus_rx = 1'b1;
    idle(4);
    expect_rd(4'd5, 16'h2, "R13 event beats clear");

    idle(4);
    if (exp_q.size() != 0) begin
      fails++;
      $display("FAIL reads outstanding: actual %0d expected 0", exp_q.size());
    end
    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end
endmodule